// File: doc/BRIEF.md
# Q15 Dual-Lane Fractional Multiplier

This block multiplies two packed pairs of signed Q15 fractional halfwords in parallel. Each lane forms the full signed product of its two 16-bit inputs and doubles it to a Q31 value. It then optionally adds half of a result LSB to round to nearest, and keeps the upper half as the Q15 result. Lane 0 takes bits 15:0 of both operands and lane 1 takes bits 31:16. Each lane result goes back into the same bit positions of the packed result.

Only one input pair cannot be represented: minus one times minus one. It is detected on the operands and replaced by the largest positive Q31 value, so that lane yields 0x7FFF whether rounding is on or off, and a sticky overflow flag is raised. The flag collects such events across operations until an explicit clear.

Results are registered one cycle after an input strobe and come with an output-valid strobe. A 64-bit writeback copy of the packed result, sign-extended from its bit 31, is provided for wide destinations.

Top module: `q15_pair_mul`

## Requirements
- R1: While reset is asserted and after its release until the first accepted operation, out_valid, res_packed, res_wide and ovf_sticky are all zero.
- R2: With round_en low, each lane result equals bits 31:16 of twice the signed 16x16 product of its inputs, the doubled product held as a 32-bit two's-complement value.
- R3: With round_en high, 0x8000 is added to the doubled 32-bit product before bits 31:16 are taken, for every input pair except the one in R4.
- R4: When both inputs of a lane are 0x8000, that lane result is 0x7FFF regardless of round_en, and ovf_sticky is 1 in the cycle the result appears.
- R5: Lane 0 uses opa[15:0] and opb[15:0] and writes res_packed[15:0]; lane 1 uses opa[31:16] and opb[31:16] and writes res_packed[31:16]; a lane's value never depends on the other lane's inputs.
- R6: res_wide[31:0] equals res_packed, and every bit of res_wide[63:32] equals res_packed[31].
- R7: out_valid is high exactly in the cycle after a cycle with in_valid high, and results computed from that cycle's inputs appear in that same cycle. Without in_valid, res_packed keeps its last value.
- R8: Once set, ovf_sticky stays 1 until a cycle with ovf_clr high. ovf_clr zeroes the flag in the next cycle unless the same cycle also accepts an R4 operation, in which case the flag is 1.
- R9: Operands presented with in_valid low, including 0x8000 pairs, change neither ovf_sticky nor res_packed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Accepts the operands this cycle |
| opa | input | 32 | First packed pair of Q15 operands |
| opb | input | 32 | Second packed pair of Q15 operands |
| round_en | input | 1 | Adds half an LSB before truncation when high |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| res_packed | output | 32 | Packed pair of Q15 results |
| res_wide | output | 64 | res_packed sign-extended from bit 31 |
| ovf_sticky | output | 1 | Sticky saturation flag |

## Verification
The assertions assume that in_valid, ovf_clr and, in cycles with in_valid high, the operands carry known 0/1 values at each rising edge after reset. They also assume these inputs change only between edges. The bench drives every input on the falling edge from fixed values or a seeded pseudo-random source, so no unknown reaches the block. It injects 0x8000 pairs on purpose in valid and idle cycles and sets ovf_clr both alone and together with a saturating operation.

// File: rtl/q15_mul_pkg.sv
`timescale 1ns/1ps
package q15_mul_pkg;
    parameter int unsigned Q15_LANE_W = 16;
    parameter int unsigned Q15_LANES  = 2;
    parameter int unsigned Q15_WIDE_W = 64;
endpackage

// File: rtl/q15_lane_mul.sv
`timescale 1ns/1ps
module q15_lane_mul #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         rnd_i,
    output logic [W-1:0] y_o,
    output logic         sat_o
);
    localparam int unsigned PW = 2 * W;
    localparam logic [W-1:0]  MIN_IN   = {1'b1, {(W-1){1'b0}}};
    localparam logic [PW-1:0] HALF_LSB = PW'(1) << (W - 1);
    localparam logic [PW-1:0] MAX_Q    = {1'b0, {(PW-1){1'b1}}};

    logic signed [PW-1:0] a_ext;
    logic signed [PW-1:0] b_ext;
    logic signed [PW-1:0] prod;
    logic        [PW-1:0] dbl;
    logic        [PW-1:0] adj;
    logic                 lane_unused;

    always_comb begin
        a_ext = {{W{a_i[W-1]}}, a_i};
        b_ext = {{W{b_i[W-1]}}, b_i};
        prod  = a_ext * b_ext;
        dbl   = {prod[PW-2:0], 1'b0};
        sat_o = (a_i == MIN_IN) && (b_i == MIN_IN);
        if (sat_o) begin
            adj = MAX_Q;
        end else if (rnd_i) begin
            adj = dbl + HALF_LSB;
        end else begin
            adj = dbl;
        end
        y_o = adj[PW-1:W];
    end

    assign lane_unused = ^{adj[W-1:0], prod[PW-1]};
endmodule

// File: rtl/q15_ovf_track.sv
`timescale 1ns/1ps
module q15_ovf_track (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = clr_i ? 1'b0 : flag_q;
        if (set_i) begin
            flag_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign flag_o = flag_q;

    p_sticky_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);

    p_clear_vs_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !flag_o) |=> !flag_o);
endmodule

// File: rtl/q15_pair_mul.sv
`timescale 1ns/1ps
module q15_pair_mul
    import q15_mul_pkg::*;
#(
    parameter int unsigned LANE_W = Q15_LANE_W,
    parameter int unsigned LANES  = Q15_LANES,
    parameter int unsigned WIDE_W = Q15_WIDE_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [LANE_W*LANES-1:0]   opa,
    input  logic [LANE_W*LANES-1:0]   opb,
    input  logic                      round_en,
    input  logic                      ovf_clr,
    output logic                      out_valid,
    output logic [LANE_W*LANES-1:0]   res_packed,
    output logic [WIDE_W-1:0]         res_wide,
    output logic                      ovf_sticky
);
    localparam int unsigned DATA_W = LANE_W * LANES;
    localparam int unsigned EXT_W  = WIDE_W - DATA_W;
    localparam logic [LANE_W-1:0] MIN_IN  = {1'b1, {(LANE_W-1){1'b0}}};
    localparam logic [LANE_W-1:0] MAX_OUT = {1'b0, {(LANE_W-1){1'b1}}};

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] res;
    } pipe_t;

    pipe_t             st_d, st_q;
    logic [DATA_W-1:0] lane_y;
    logic [LANES-1:0]  lane_sat;
    logic              ovf_set;

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            q15_lane_mul #(.W(LANE_W)) u_lane (
                .a_i   (opa[g*LANE_W +: LANE_W]),
                .b_i   (opb[g*LANE_W +: LANE_W]),
                .rnd_i (round_en),
                .y_o   (lane_y[g*LANE_W +: LANE_W]),
                .sat_o (lane_sat[g])
            );
        end
    endgenerate

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.res = lane_y;
        end
        ovf_set = in_valid && (|lane_sat);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    q15_ovf_track u_ovf (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (ovf_set),
        .clr_i  (ovf_clr),
        .flag_o (ovf_sticky)
    );

    assign out_valid  = st_q.vld;
    assign res_packed = st_q.res;
    assign res_wide   = {{EXT_W{st_q.res[DATA_W-1]}}, st_q.res};

    p_valid_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(res_packed));

    p_special_sat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opa[LANE_W-1:0] == MIN_IN && opb[LANE_W-1:0] == MIN_IN)
        |=> (res_packed[LANE_W-1:0] == MAX_OUT && ovf_sticky));

    p_zero_lane_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !round_en && opa[LANE_W-1:0] == '0)
        |=> (res_packed[LANE_W-1:0] == '0));
endmodule

// File: tb/q15_pair_mul_bench.sv
`timescale 1ns/1ps
module q15_pair_mul_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic        round_en = 1'b0;
    logic        ovf_clr = 1'b0;
    logic        out_valid;
    logic [31:0] res_packed;
    logic [63:0] res_wide;
    logic        ovf_sticky;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    bit          exp_v = 1'b0;
    logic [31:0] exp_res = '0;
    bit          exp_flag = 1'b0;

    always #10 clk = ~clk;

    q15_pair_mul u_q15_pair_mul (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opa(opa), .opb(opb),
        .round_en(round_en), .ovf_clr(ovf_clr), .out_valid(out_valid),
        .res_packed(res_packed), .res_wide(res_wide), .ovf_sticky(ovf_sticky)
    );

    function automatic logic [15:0] ref_lane(input logic [15:0] a, input logic [15:0] b, input bit rnd);
        longint sa;
        longint sb;
        longint q;
        if (a == 16'h8000 && b == 16'h8000) return 16'h7FFF;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        q = sa * sb * 2;
        if (rnd) q = q + 32768;
        return q[31:16];
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        logic [63:0] wexp;
        wexp = {{32{exp_res[31]}}, exp_res};
        check(out_valid == exp_v, tag, "out_valid (R7)", 64'(out_valid), 64'(exp_v));
        check(res_packed == exp_res, tag, "res_packed", 64'(res_packed), 64'(exp_res));
        check(res_wide == wexp, tag, "res_wide (R6)", res_wide, wexp);
        check(ovf_sticky == exp_flag, tag, "ovf_sticky", 64'(ovf_sticky), 64'(exp_flag));
    endtask

    task automatic step(input bit v, input logic [31:0] a, input logic [31:0] b,
                        input bit r, input bit c, input string tag);
        bit sat_any;
        @(negedge clk);
        in_valid = v; opa = a; opb = b; round_en = r; ovf_clr = c;
        sat_any = (a[15:0] == 16'h8000 && b[15:0] == 16'h8000) ||
                  (a[31:16] == 16'h8000 && b[31:16] == 16'h8000);
        exp_v = v;
        if (v) exp_res = {ref_lane(a[31:16], b[31:16], r), ref_lane(a[15:0], b[15:0], r)};
        if (c) exp_flag = 1'b0;
        if (v && sat_any) exp_flag = 1'b1;
        @(posedge clk);
        #5;
        compare_all(tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #5;
        compare_all("R1");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #5;
        compare_all("R1");

        // R2 plain products: 0.5*0.5 and -0.5*0.25
        step(1, 32'hC000_4000, 32'h2000_4000, 0, 0, "R2");
        step(1, 32'h7FFF_7FFF, 32'h7FFF_8000, 0, 0, "R2");
        // R3 rounding pushes doubled 0x8000 fraction up; negative tiny product rounds to zero
        step(1, 32'hFFFF_0100, 32'h0001_0040, 0, 0, "R2");
        step(1, 32'hFFFF_0100, 32'h0001_0040, 1, 0, "R3");
        step(1, 32'h00FF_0123, 32'h0081_7ABC, 1, 0, "R3");
        // R6 negative high lane for sign extension
        step(1, 32'h8001_1234, 32'h7FFF_1234, 0, 0, "R6");
        // R4 low-lane special case, both rounding settings
        step(1, 32'h1000_8000, 32'h1000_8000, 0, 0, "R4");
        step(1, 32'h0000_8000, 32'h0000_8000, 1, 0, "R4");
        // R8 flag held through normal ops
        step(1, 32'h0100_0100, 32'h0100_0100, 0, 0, "R8");
        step(0, 32'h0, 32'h0, 0, 0, "R8");
        step(0, 32'h0, 32'h0, 0, 1, "R8");
        // R5 high-lane-only special case, low lane independent
        step(1, 32'h8000_3000, 32'h8000_D000, 1, 0, "R5");
        step(1, 32'h3000_8000, 32'hD000_7FFF, 0, 1, "R5");
        // R8 clear coinciding with an overflow keeps the flag set
        step(1, 32'h8000_0000, 32'h8000_0000, 0, 1, "R8");
        step(0, 32'h0, 32'h0, 0, 1, "R8");
        // R9 idle cycles with saturating operands change nothing
        step(0, 32'h8000_8000, 32'h8000_8000, 1, 0, "R9");
        step(0, 32'h1234_5678, 32'h9ABC_DEF0, 0, 0, "R9");
        // R7 back-to-back then idle hold
        step(1, 32'h4000_C000, 32'h4000_4000, 0, 0, "R7");
        step(1, 32'h7FFF_0001, 32'h0001_7FFF, 1, 0, "R7");
        step(0, 32'h0, 32'h0, 0, 0, "R7");
        // R2 R3 R5 pseudo-random sweep with injected saturating pairs
        for (int i = 0; i < 600; i++) begin
            logic [31:0] ra, rb;
            ra = $urandom();
            rb = $urandom();
            if (i % 17 == 0) begin ra[15:0] = 16'h8000; rb[15:0] = 16'h8000; end
            if (i % 23 == 0) begin ra[31:16] = 16'h8000; rb[31:16] = 16'h8000; end
            step(($urandom() % 4) != 0, ra, rb, ($urandom() % 2) == 1,
                 ($urandom() % 9) == 0, "R5");
        end
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule